// File: doc/BRIEF.md
# Bus Error Trap with Interrupt

This block sits beside a PCI host bridge and records four kinds of bus failure: a system error signalled by another agent, a data parity error signalled by another agent, a master abort and a target abort. The bridge's detection logic delivers each failure as a one-cycle event pulse, together with the bus address of the transaction in progress. The block does not detect errors itself. It only records them.

Each source has a sticky status flag and a mask flag. A single level-sensitive interrupt line is high while any flag is set and its mask is clear. The block also holds the bus address of the first failure that arrives while the address holder is empty. Software reads that address, and the read empties the holder. Software clears the status flags by writing ones to a separate field of the control word. The function is intended for debug use. After reset every source is masked, so the interrupt stays quiet until software unmasks a source.

Top module: `bus_err_monitor`

## Requirements
- R1: After reset the control word at offset 0x18 reads 0x00000F00, the address word at offset 0x1C reads 0, and the interrupt is low.
- R2: Source bit positions are: bit 0 = system error received, bit 1 = parity error received, bit 2 = master abort, bit 3 = target abort. An event pulse on source i sets status bit i of the control word (bits 3:0). The bit stays set on later cycles with no event.
- R3: Writing the control word with bit 16+i set clears status bit i. A written 0 in bits 19:16 leaves status unchanged, and writes to bits 3:0 have no effect on status.
- R4: When an event and a clear for the same source land in the same cycle, the status bit ends up set.
- R5: Control bits 11:8 are per-source masks that software can read and write. The interrupt is high exactly when some status bit i is set and mask bit i is clear.
- R6: An error arriving while the address word holds zero loads the transaction address into the address word.
- R7: While the address word is nonzero, later errors leave it unchanged.
- R8: A read of the address word returns its value and leaves the word zero afterwards. If an error arrives in the same cycle as that read, the word takes the new transaction address instead.
- R9: Clear bits 19:16, all other unused control bits and any unmapped offset read as zero.
- R10: The interrupt is a level: once high it stays high on idle cycles until the status bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt_i | input | 4 | One-cycle event pulses, one per source |
| txn_addr_i | input | 32 | Bus address of the current transaction |
| reg_sel_i | input | 1 | Register access select |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_ofs_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid during a read |
| err_irq_o | output | 1 | Combined error interrupt, level |

## Verification
The bench builds the block with its defaults: four sources, a 32-bit address and the control and address words at 0x18 and 0x1C. With only four sources it can sweep every pairing of the 16 event patterns with the 16 mask patterns and compute the expected interrupt level and control word arithmetically for each pairing. Directed sequences then cover the address holder's first-capture rule, clear-on-read, a read that coincides with a new error, and an event that coincides with a clear.

// File: rtl/bem_pkg.sv
package bem_pkg;

    // Field positions inside the control word (software-visible layout)
    localparam int unsigned STAT_LSB = 0;
    localparam int unsigned MASK_LSB = 8;
    localparam int unsigned CLR_LSB  = 16;

    // Source index order (status, mask and clear fields share it)
    typedef enum logic [1:0] {
        SRC_SYS_ERR  = 2'd0,
        SRC_PAR_ERR  = 2'd1,
        SRC_MST_ABRT = 2'd2,
        SRC_TGT_ABRT = 2'd3
    } err_src_e;

endpackage

// File: rtl/bem_status.sv
module bem_status #(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic [N_SRC-1:0] clr_i,
    input  logic             mask_we_i,
    input  logic [N_SRC-1:0] mask_wdata_i,
    output logic [N_SRC-1:0] status_o,
    output logic [N_SRC-1:0] mask_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [N_SRC-1:0] status;
        logic [N_SRC-1:0] mask;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (mask_we_i) begin
            state_d.mask = mask_wdata_i;
        end
        for (int i = 0; i < N_SRC; i++) begin
            // a new event outranks a clear in the same cycle
            if (evt_i[i]) begin
                state_d.status[i] = 1'b1;
            end else if (clr_i[i]) begin
                state_d.status[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{status: '0, mask: '1};
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o = state_q.status;
    assign mask_o   = state_q.mask;
    assign irq_o    = |(state_q.status & ~state_q.mask);

endmodule

// File: rtl/bem_addr_hold.sv
module bem_addr_hold #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_evt_i,
    input  logic [AW-1:0] addr_i,
    input  logic          rd_clr_i,
    output logic [AW-1:0] held_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } state_t;

    state_t state_d, state_q;

    logic empty;
    assign empty = (state_q.addr == '0);

    always_comb begin
        state_d = state_q;
        if (any_evt_i && (empty || rd_clr_i)) begin
            state_d.addr = addr_i;
        end else if (rd_clr_i) begin
            state_d.addr = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{addr: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign held_o = state_q.addr;

endmodule

// File: rtl/bem_regif.sv
module bem_regif #(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned OFS_W     = 8,
    parameter int unsigned CTRL_OFS  = 8'h18,
    parameter int unsigned EADDR_OFS = 8'h1C
) (
    input  logic             sel_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [OFS_W-1:0] ofs_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic [N_SRC-1:0] status_i,
    input  logic [N_SRC-1:0] mask_i,
    input  logic [AW-1:0]    held_i,
    output logic [N_SRC-1:0] clr_o,
    output logic             mask_we_o,
    output logic [N_SRC-1:0] mask_wdata_o,
    output logic             rd_clr_o,
    output logic [DW-1:0]    rdata_o
);

    import bem_pkg::*;

    localparam logic [OFS_W-1:0] CTRL_SEL  = OFS_W'(CTRL_OFS);
    localparam logic [OFS_W-1:0] EADDR_SEL = OFS_W'(EADDR_OFS);

    logic hit_ctrl, hit_eaddr, wr_ctrl;
    assign hit_ctrl  = sel_i && (ofs_i == CTRL_SEL);
    assign hit_eaddr = sel_i && (ofs_i == EADDR_SEL);
    assign wr_ctrl   = hit_ctrl && wr_i;

    assign mask_we_o    = wr_ctrl;
    assign mask_wdata_o = wdata_i[MASK_LSB +: N_SRC];
    assign rd_clr_o     = hit_eaddr && rd_i;

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_clr
        assign clr_o[gi] = wr_ctrl && wdata_i[CLR_LSB + gi];
    end

    logic [DW-1:0] ctrl_word, eaddr_word;
    always_comb begin
        ctrl_word = '0;
        ctrl_word[STAT_LSB +: N_SRC] = status_i;
        ctrl_word[MASK_LSB +: N_SRC] = mask_i;
        eaddr_word = '0;
        eaddr_word[AW-1:0] = held_i;
    end

    always_comb begin
        rdata_o = '0;
        if (rd_i && hit_ctrl) begin
            rdata_o = ctrl_word;
        end else if (rd_i && hit_eaddr) begin
            rdata_o = eaddr_word;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata_i[STAT_LSB +: N_SRC], wdata_i[DW-1:CLR_LSB+N_SRC],
                            wdata_i[CLR_LSB-1:MASK_LSB+N_SRC], wdata_i[MASK_LSB-1:STAT_LSB+N_SRC]};

endmodule

// File: rtl/bus_err_monitor.sv
module bus_err_monitor #(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned AW        = 32,
    parameter int unsigned DW        = 32,
    parameter int unsigned OFS_W     = 8,
    parameter int unsigned CTRL_OFS  = 8'h18,
    parameter int unsigned EADDR_OFS = 8'h1C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] err_evt_i,
    input  logic [AW-1:0]    txn_addr_i,
    input  logic             reg_sel_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [OFS_W-1:0] reg_ofs_i,
    input  logic [DW-1:0]    reg_wdata_i,
    output logic [DW-1:0]    reg_rdata_o,
    output logic             err_irq_o
);

    logic [N_SRC-1:0] status, mask, clr, mask_wdata;
    logic             mask_we, rd_clr, any_evt;
    logic [AW-1:0]    held;

    assign any_evt = |err_evt_i;

    bem_status #(.N_SRC(N_SRC)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (err_evt_i),
        .clr_i        (clr),
        .mask_we_i    (mask_we),
        .mask_wdata_i (mask_wdata),
        .status_o     (status),
        .mask_o       (mask),
        .irq_o        (err_irq_o)
    );

    bem_addr_hold #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_evt_i (any_evt),
        .addr_i    (txn_addr_i),
        .rd_clr_i  (rd_clr),
        .held_o    (held)
    );

    bem_regif #(
        .N_SRC     (N_SRC),
        .AW        (AW),
        .DW        (DW),
        .OFS_W     (OFS_W),
        .CTRL_OFS  (CTRL_OFS),
        .EADDR_OFS (EADDR_OFS)
    ) u_regif (
        .sel_i        (reg_sel_i),
        .wr_i         (reg_wr_i),
        .rd_i         (reg_rd_i),
        .ofs_i        (reg_ofs_i),
        .wdata_i      (reg_wdata_i),
        .status_i     (status),
        .mask_i       (mask),
        .held_i       (held),
        .clr_o        (clr),
        .mask_we_o    (mask_we),
        .mask_wdata_o (mask_wdata),
        .rd_clr_o     (rd_clr),
        .rdata_o      (reg_rdata_o)
    );

endmodule

// File: rtl/bem_checker.sv
module bem_checker #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned AW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] evt,
    input logic [N_SRC-1:0] clr,
    input logic [N_SRC-1:0] status,
    input logic             mask_we,
    input logic             rd_clr,
    input logic             any_evt,
    input logic [AW-1:0]    held,
    input logic             irq
);

    // R5: the interrupt only rises after an event or a mask update
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|evt) || $past(mask_we)));

    // R2: a set status bit survives unless a clear was written for it
    assert_status_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0));

    // R4: every event leaves its status bit set, even against a clear
    assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~status) == '0));

    // R7: a nonzero held address is not overwritten without a read
    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((held != '0) && !rd_clr) |=> $stable(held));

    // R8: a read with no concurrent error empties the holder
    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !any_evt) |=> (held == '0));

endmodule

bind bus_err_monitor bem_checker #(.N_SRC(N_SRC), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (err_evt_i),
    .clr     (clr),
    .status  (status),
    .mask_we (mask_we),
    .rd_clr  (rd_clr),
    .any_evt (any_evt),
    .held    (held),
    .irq     (err_irq_o)
);

// File: tb/bus_err_monitor_bench.sv
`timescale 1ns/1ps
module bus_err_monitor_bench;

    localparam logic [7:0] CTRL  = 8'h18;
    localparam logic [7:0] EADDR = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  err_evt_i = '0;
    logic [31:0] txn_addr_i = '0;
    logic        reg_sel_i = 1'b0, reg_wr_i = 1'b0, reg_rd_i = 1'b0;
    logic [7:0]  reg_ofs_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        err_irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bus_err_monitor u_bus_err_monitor (
        .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i), .txn_addr_i(txn_addr_i),
        .reg_sel_i(reg_sel_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
        .reg_ofs_i(reg_ofs_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .err_irq_o(err_irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] ofs, input logic [31:0] data);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_wr_i = 1'b1; reg_ofs_i = ofs; reg_wdata_i = data;
        @(negedge clk);
        reg_sel_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic do_read(input logic [7:0] ofs, output logic [31:0] val);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_rd_i = 1'b1; reg_ofs_i = ofs;
        #1 val = reg_rdata_o;
        @(negedge clk);
        reg_sel_i = 1'b0; reg_rd_i = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] evt, input logic [31:0] addr);
        @(negedge clk);
        err_evt_i = evt; txn_addr_i = addr;
        @(negedge clk);
        err_evt_i = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, err_irq_o}, 32'd0);
        do_read(CTRL, v);  check("R1 ctrl", v, 32'h0000_0F00);
        do_read(EADDR, v); check("R1 eaddr", v, 32'd0);

        // R2/R5/R3 sweep: every mask against every event pattern
        for (int m = 0; m < 16; m++) begin
            for (int e = 0; e < 16; e++) begin
                do_write(CTRL, 32'h000F_0000 | (32'(m) << 8));
                pulse(4'(e), 32'h100 + 32'(e));
                check("R5 irq sweep", {31'd0, err_irq_o},
                      {31'd0, |(4'(e) & ~4'(m))});
                do_read(CTRL, v);
                check("R2 ctrl sweep", v, (32'(m) << 8) | 32'(e));
            end
        end
        do_read(EADDR, v); // empty the holder

        // R10: level holds over idle cycles; R3: zero clear and status-bit writes ignored
        do_write(CTRL, 32'h000F_0000);
        pulse(4'b0100, 32'h0);
        repeat (5) @(negedge clk);
        check("R10 irq held", {31'd0, err_irq_o}, 32'd1);
        do_write(CTRL, 32'h0000_000F);
        check("R3 zero clear keeps irq", {31'd0, err_irq_o}, 32'd1);
        do_read(CTRL, v); check("R3 status kept", v, 32'h0000_0004);
        do_write(CTRL, 32'h0004_0000);
        do_read(CTRL, v); check("R3 clear one", v, 32'h0000_0000);
        check("R10 irq dropped", {31'd0, err_irq_o}, 32'd0);

        // R4: event and clear together
        @(negedge clk);
        err_evt_i = 4'b0010; txn_addr_i = 32'h0;
        reg_sel_i = 1'b1; reg_wr_i = 1'b1; reg_ofs_i = CTRL; reg_wdata_i = 32'h000F_0F00;
        @(negedge clk);
        err_evt_i = '0; reg_sel_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
        do_read(CTRL, v); check("R4 event beats clear", v, 32'h0000_0F02);

        // R9: clear bits and unused bits read zero, unmapped offset reads zero
        do_write(CTRL, 32'hFFFF_FFFF);
        do_read(CTRL, v); check("R9 ctrl readback", v, 32'h0000_0F00);
        do_read(8'h00, v); check("R9 unmapped", v, 32'd0);

        // R6/R7/R8 address holder
        do_read(EADDR, v);
        pulse(4'b0001, 32'hA5A5_0010);
        pulse(4'b1000, 32'h5A5A_0020);
        do_read(EADDR, v); check("R6 first capture", v, 32'hA5A5_0010);
        do_read(EADDR, v); check("R8 cleared by read", v, 32'd0);
        pulse(4'b0010, 32'h1234_5678);
        pulse(4'b0100, 32'h0BAD_0000);
        pulse(4'b0001, 32'h0BAD_0004);
        do_read(EADDR, v); check("R7 no overwrite", v, 32'h1234_5678);
        pulse(4'b0001, 32'hCAFE_0000);
        @(negedge clk);
        reg_sel_i = 1'b1; reg_rd_i = 1'b1; reg_ofs_i = EADDR;
        err_evt_i = 4'b1000; txn_addr_i = 32'hD00D_0040;
        #1 v = reg_rdata_o;
        check("R8 read returns old", v, 32'hCAFE_0000);
        @(negedge clk);
        reg_sel_i = 1'b0; reg_rd_i = 1'b0; err_evt_i = '0;
        do_read(EADDR, v); check("R8 read with event", v, 32'hD00D_0040);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule